// File: doc/BRIEF.md
# Supply and Chip-Select Watchdog Reset Generator

This block produces the system reset for a processor subsystem. It combines three causes. The first is the start-up period after power is applied. The second is a digital indication that the supply rail is at or above its threshold. The third is a watchdog that watches the serial chip-select line. The reset stays active while the supply indication is low. Once the supply is good, the reset stays active for a programmable hold interval, measured in pulses of a slow timebase strobe (typically one pulse per millisecond, so the default of 200 pulses gives about 200 ms). Any drop of the supply indication during the hold starts the interval again from zero.

When the watchdog is enabled, only a falling edge on chip select counts as servicing. The line is first passed through a two-flop synchroniser. If chip select stays high, or stays low, for longer than the selected timeout, a watchdog trip occurs. The trip asserts reset for one full hold interval, and the watchdog count then starts again from zero. A two-bit code picks one of four timeout lengths. The reset is presented in both polarities. Each output is a registered level that the chip's pad ring can use to drive an open-drain pin. The analog comparator and the trimming of its threshold are outside this block.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 1 and `rst_out_n` is 0.
- R2: A low `supply_ok` sampled at a clock edge makes `rst_out` 1 after that same edge. Reset stays asserted while `supply_ok` is low, whatever `tick` does.
- R3: With `supply_ok` held high and no watchdog trip, reset is released at the clock edge that samples the HOLD_TICKS-th `tick` pulse counted since the hold began, and not earlier.
- R4: A single clock cycle of low `supply_ok` during the hold interval restarts the count, so HOLD_TICKS fresh `tick` pulses are needed afterwards.
- R5: With `wd_en` = 1 and `cs_n` held high, reset asserts at the edge that samples the N-th `tick` after the watchdog count was last cleared, where N is the selected timeout.
- R6: A `cs_n` held low also trips the watchdog after N ticks. A rising edge on `cs_n` does not service the watchdog.
- R7: A falling edge of `cs_n`, seen after two synchroniser stages, clears the watchdog count. A full N further ticks are then needed to trip it.
- R8: With `wd_en` = 0 the watchdog never asserts reset, for any number of ticks.
- R9: `wd_sel` codes 0, 1, 2 and 3 select the timeouts WD_T0, WD_T1, WD_T2 and WD_T3 ticks.
- R10: A watchdog trip holds reset for exactly HOLD_TICKS ticks. The watchdog count stays at zero while reset is active, and it starts from zero after release.
- R11: `rst_out_n` is always the complement of `rst_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| tick | input | 1 | Single-cycle timebase strobe that advances the hold and watchdog counts |
| supply_ok | input | 1 | Supply at or above threshold (synchronous to clk) |
| cs_n | input | 1 | Serial chip-select line, asynchronous |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Watchdog timeout selection code |
| rst_out_n | output | 1 | Active-low reset, meant for an open-drain pad |
| rst_out | output | 1 | Active-high reset, meant for an open-drain pad |

## Verification
The assertions assume four things: `supply_ok` is already synchronous to `clk`, `tick` is a pulse no longer than one clock cycle, every timeout parameter is at least one, and `wd_sel` only changes while the watchdog count is below every limit. The stimulus changes all inputs on the falling clock edge and raises `tick` for exactly one cycle at a time. It keeps `wd_sel` steady within each watchdog interval and changes it only just after a hold release, when the count is zero. After it drops chip select, it leaves idle cycles before the next tick, so the synchronised edge clears the count before counting resumes.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        WD_SEL_T0 = 2'd0,
        WD_SEL_T1 = 2'd1,
        WD_SEL_T2 = 2'd2,
        WD_SEL_T3 = 2'd3
    } wd_sel_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/supv_cs_sync.sv
module supv_cs_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_fall
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[PIPE_W-2:0], cs_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pipe: '1};
        else        st_q <= st_d;
    end

    // previous synchronised level high, current synchronised level low
    assign cs_fall = st_q.pipe[PIPE_W-1] & ~st_q.pipe[PIPE_W-2];

    // R7
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !cs_fall);

endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer #(
    parameter int WD_T0 = 150,
    parameter int WD_T1 = 600,
    parameter int WD_T2 = 1400,
    parameter int WD_T3 = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    input  logic       service,
    input  logic       hold,
    output logic       trip
);
    import supv_pkg::*;

    localparam int WD_MAX = max2(max2(WD_T0, WD_T1), max2(WD_T2, WD_T3));
    localparam int WD_W   = $clog2(WD_MAX + 1);
    localparam logic [WD_W-1:0] ONE = WD_W'(1);

    typedef struct packed {
        logic [WD_W-1:0] cnt;
    } wd_st_t;

    wd_st_t          st_d, st_q;
    logic [WD_W-1:0] limit;
    logic            clear;

    always_comb begin
        unique case (wd_sel_e'(wd_sel))
            WD_SEL_T0: limit = WD_W'(WD_T0);
            WD_SEL_T1: limit = WD_W'(WD_T1);
            WD_SEL_T2: limit = WD_W'(WD_T2);
            default:   limit = WD_W'(WD_T3);
        endcase
    end

    always_comb begin
        st_d  = st_q;
        clear = !wd_en || service || hold;
        trip  = !clear && tick && (st_q.cnt >= limit - ONE);
        if (clear)     st_d.cnt = '0;
        else if (trip) st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < WD_W'(WD_MAX));

    // R7
    service_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        service |=> st_q.cnt == '0);

    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> (st_q.cnt == '0 && !trip));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !trip);

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
    parameter int HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic trip,
    output logic active
);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam logic [HOLD_W-1:0] LAST = HOLD_W'(HOLD_TICKS - 1);

    typedef struct packed {
        logic              active;
        logic [HOLD_W-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!supply_ok || trip) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && tick) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + HOLD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    // R2
    low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> active);

    // R3
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(tick) && $past(supply_ok) && !$past(trip)));

    // R4
    dip_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> st_q.cnt == '0);

    // R10
    trip_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (active && st_q.cnt == '0));

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
    parameter int HOLD_TICKS  = 200,
    parameter int WD_T0       = 150,
    parameter int WD_T1       = 600,
    parameter int WD_T2       = 1400,
    parameter int WD_T3       = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_ok,
    input  logic       cs_n,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    output logic       rst_out_n,
    output logic       rst_out
);
    logic cs_fall;
    logic wd_trip;
    logic hold_active;

    supv_cs_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .cs_fall(cs_fall)
    );

    supv_wd_timer #(
        .WD_T0(WD_T0),
        .WD_T1(WD_T1),
        .WD_T2(WD_T2),
        .WD_T3(WD_T3)
    ) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wd_en  (wd_en),
        .wd_sel (wd_sel),
        .service(cs_fall),
        .hold   (hold_active),
        .trip   (wd_trip)
    );

    supv_hold_timer #(
        .HOLD_TICKS(HOLD_TICKS)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .supply_ok(supply_ok),
        .trip     (wd_trip),
        .active   (hold_active)
    );

    assign rst_out   = hold_active;
    assign rst_out_n = ~hold_active;

    // R5
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> ($past(!supply_ok) || $past(wd_trip)));

    // R8
    wd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en && supply_ok && !rst_out) |=> !rst_out);

endmodule

// File: tb/tb_supv_reset_gen.sv
module tb_supv_reset_gen;
    localparam int CLK_P = 10;
    localparam int HOLD  = 4;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       supply_ok = 1'b0;
    logic       cs_n = 1'b1;
    logic       wd_en = 1'b0;
    logic [1:0] wd_sel = 2'd0;
    logic       rst_out_n, rst_out;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    item_t q[$];

    supv_reset_gen #(
        .HOLD_TICKS(HOLD), .WD_T0(3), .WD_T1(5), .WD_T2(7), .WD_T3(9)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .cs_n(cs_n), .wd_en(wd_en), .wd_sel(wd_sel),
        .rst_out_n(rst_out_n), .rst_out(rst_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive tick, queue expected reset level after the coming edge
    task automatic cyc(input logic t, input logic exp, input string tag);
        item_t it;
        tick   = t;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic run(input int n, input logic exp_pre, input logic exp_last, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, (i == n - 1) ? exp_last : exp_pre, tag);
    endtask

    task automatic idle(input int n, input logic exp, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, exp, tag);
    endtask

    // monitor: compares outputs a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(rst_out, it.exp, it.tag);
                check(rst_out_n, ~it.exp, "R11 polarity");
            end
        end
    end

    initial begin
        #(CLK_P * 50000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rst_out, 1'b1, "R1 reset high");
        check(rst_out_n, 1'b0, "R1 reset low");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: ticks while supply low never release
        run(6, 1'b1, 1'b1, "R2 supply low");
        // R3/R4: partial hold, dip, then full hold
        supply_ok = 1'b1;
        run(HOLD - 1, 1'b1, 1'b1, "R3 hold early");
        supply_ok = 1'b0;
        cyc(1'b0, 1'b1, "R4 dip");
        supply_ok = 1'b1;
        run(HOLD, 1'b1, 1'b0, "R4 restart then R3 release");
        idle(3, 1'b0, "R3 stays released");
        // R2: immediate assertion without tick
        supply_ok = 1'b0;
        cyc(1'b0, 1'b1, "R2 immediate");
        supply_ok = 1'b1;
        run(HOLD, 1'b1, 1'b0, "R3 re-release");

        // R5/R9: stuck high, code 0 -> 3 ticks
        wd_en = 1'b1;
        wd_sel = 2'd0;
        run(3, 1'b0, 1'b1, "R5 stuck high code0");
        run(HOLD, 1'b1, 1'b0, "R10 trip hold");
        // R10 restart from zero, then R7 service by falling edge
        run(2, 1'b0, 1'b0, "R10 count restarted");
        cs_n = 1'b0;
        idle(3, 1'b0, "R7 edge sync");
        run(2, 1'b0, 1'b0, "R7 serviced");
        cyc(1'b1, 1'b1, "R6 stuck low");
        run(HOLD, 1'b1, 1'b0, "R10 trip hold 2");
        // R9: code 3 -> 9 ticks, rising edge gives no service (R6)
        wd_sel = 2'd3;
        cs_n = 1'b1;
        idle(3, 1'b0, "R6 rising edge");
        run(9, 1'b0, 1'b1, "R9 code3");
        run(HOLD, 1'b1, 1'b0, "R10 trip hold 3");
        wd_sel = 2'd1;
        run(5, 1'b0, 1'b1, "R9 code1");
        run(HOLD, 1'b1, 1'b0, "R10 trip hold 4");
        wd_sel = 2'd2;
        run(7, 1'b0, 1'b1, "R9 code2");
        run(HOLD, 1'b1, 1'b0, "R10 trip hold 5");
        // R8: disabled watchdog never trips
        wd_en = 1'b0;
        run(25, 1'b0, 1'b0, "R8 disabled");
        // R2 with watchdog enabled
        wd_en = 1'b1;
        supply_ok = 1'b0;
        cyc(1'b1, 1'b1, "R2 low with wd");
        supply_ok = 1'b1;
        run(HOLD, 1'b1, 1'b0, "R3 final release");
        tick = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule